// File: doc/BRIEF.md
# USB Host Status Register Unit

This unit holds the status word of a USB 2.0 host controller and the microframe index counter that goes with it. A free-running clock divider marks a microframe boundary every `CLK_DIV` cycles, which is 125 us at the intended clock. While the controller runs, the frame index advances by one at each boundary. The unit keeps a set of status flags and drives a single interrupt line.

Its inputs come from two places. The command register supplies run/stop, the two schedule enables, the frame list size and the async-advance doorbell. The schedule engine supplies one-cycle strobes for async advance done, async schedule empty and internal-error halt. The status word is always readable on `rd_data_o`. A write clears every write-one-to-clear flag whose bit is 1 in the written data.

The schedule status bits and the halted bit report the state the controller has actually reached, so they follow their controls with a lag. The rollover flag watches a different frame index bit for each frame list size.

Top module: `usbh_status_unit`

## Requirements
- R1: After reset the status word reads 0x0000_1000 (only the halted bit, bit 12, is set), `frame_idx_o` is 0 and `irq_o` is 0.
- R2: The halted bit (bit 12) reads 0 one cycle after `run_stop_i` is seen high, provided no error halt is pending. After `run_stop_i` drops, the bit goes to 1 at the next microframe boundary and not before.
- R3: An `err_halt_i` strobe sets the halted bit in the next cycle, even while `run_stop_i` stays high. The bit stays 1 until `run_stop_i` has been seen low; a later high on `run_stop_i` restarts the controller.
- R4: A microframe boundary occurs every `CLK_DIV` cycles. The 14-bit frame index increments by one at each boundary only while `run_stop_i` is 1 and the halted bit is 0. Otherwise the index holds.
- R5: The microframe-received bit (bit 7) is set at every boundary at which the controller is not halted, and is write-one-to-clear.
- R6: The async schedule status bit (bit 15) copies `async_en_i`, and the periodic schedule status bit (bit 14) copies `periodic_en_i`. Each copy is taken only at a microframe boundary, so a change of enable is not visible before the next boundary.
- R7: The async-advance bit (bit 5) is set by an `adv_done_i` strobe only if `doorbell_i` has pulsed since the last time the bit was set. An `adv_done_i` strobe without a preceding doorbell is ignored. The bit is write-one-to-clear.
- R8: The reclamation bit (bit 13) is set by an `async_empty_i` strobe and cleared at the next microframe boundary. It is not writable.
- R9: The rollover bit (bit 3) is set when a frame index advance toggles the index bit picked by `fl_size_i`: bit 13 for code 0 (1024 entries), bit 12 for code 1 (512 entries), bit 11 for codes 2 and 3 (256 entries). An advance that toggles only a lower index bit leaves the rollover bit unchanged. The bit is write-one-to-clear.
- R10: A write clears only bits 3, 5 and 7. If a set event for one of these bits falls in the same cycle as its clear, the bit ends up set. All other bits ignore writes, and bit 4 and every reserved bit read 0.
- R11: `irq_o` is the OR over bits 3, 5 and 7 of the status bit ANDed with the same bit of `intr_en_i`, with no added cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_stop_i | input | 1 | Run/stop control from the command register |
| async_en_i | input | 1 | Async schedule enable |
| periodic_en_i | input | 1 | Periodic schedule enable |
| fl_size_i | input | 2 | Frame list size code: 0 = 1024, 1 = 512, 2/3 = 256 entries |
| doorbell_i | input | 1 | Async-advance doorbell pulse |
| adv_done_i | input | 1 | Strobe: schedule engine advanced the async schedule |
| async_empty_i | input | 1 | Strobe: a pass found the async schedule empty |
| err_halt_i | input | 1 | Strobe: internal error forces a halt |
| wr_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 32 | Write data; a 1 clears the matching write-one-to-clear bit |
| intr_en_i | input | 32 | Interrupt enable per status bit |
| rd_data_o | output | 32 | Status word |
| frame_idx_o | output | 14 | Microframe index |
| irq_o | output | 1 | Interrupt request |

## Verification
A fault in the divider or in the index counter shows within one microframe, as a frame index that steps at the wrong time or by the wrong amount. A schedule or halted bit that latches outside a boundary is visible on the status word in the very next cycle. It is caught by sampling just after each enable or run/stop change and again just after the following boundary. A rollover tap on the wrong index bit stays hidden until that bit toggles. For that reason the bench runs the index through the bit 11, 12 and 13 transitions for each size code, and also runs one bit 11 transition under the 512-entry code, where the rollover flag must stay clear.

// File: rtl/usbh_sts_pkg.sv
package usbh_sts_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FRI_BIT = 3;
  localparam int unsigned SEI_BIT = 4;
  localparam int unsigned AAI_BIT = 5;
  localparam int unsigned SRI_BIT = 7;
  localparam int unsigned HCH_BIT = 12;
  localparam int unsigned RCL_BIT = 13;
  localparam int unsigned PS_BIT  = 14;
  localparam int unsigned AS_BIT  = 15;

  typedef enum logic [1:0] {
    FL_1024 = 2'd0,
    FL_512  = 2'd1,
    FL_256  = 2'd2,
    FL_256B = 2'd3
  } fl_size_e;

  // index bit whose toggle marks a list wrap
  function automatic int unsigned roll_pos(input logic [1:0] code, input int unsigned idx_w);
    case (fl_size_e'(code))
      FL_1024: roll_pos = idx_w - 1;
      FL_512:  roll_pos = idx_w - 2;
      default: roll_pos = idx_w - 3;
    endcase
  endfunction
endpackage

// File: rtl/usbh_uframe_timer.sv
module usbh_uframe_timer #(
  parameter int unsigned CLK_DIV = 7500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && CLK_DIV > 1) |=> !tick_o);
endmodule

// File: rtl/usbh_frame_index.sv
module usbh_frame_index
  import usbh_sts_pkg::*;
#(
  parameter int unsigned IDX_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [1:0]       fl_size_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             roll_o
);
  localparam int unsigned POS_W = $clog2(IDX_W);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [POS_W-1:0] pos;

  assign idx_nxt = idx_q + 1'b1;
  assign pos     = POS_W'(roll_pos(fl_size_i, IDX_W));
  assign roll_o  = adv_i & (idx_q[pos] ^ idx_nxt[pos]);
  assign idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_nxt;
  end

  // R4
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_o));
endmodule

// File: rtl/usbh_sched_state.sv
module usbh_sched_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_stop_i,
  input  logic err_halt_i,
  input  logic async_en_i,
  input  logic periodic_en_i,
  output logic halted_o,
  output logic as_o,
  output logic ps_o
);
  localparam int unsigned N_SCHED = 2;

  logic [N_SCHED-1:0] en, sts_q;
  logic hch_q, lock_q;

  assign en = {async_en_i, periodic_en_i};

  for (genvar g = 0; g < N_SCHED; g++) begin : g_sched
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sts_q[g] <= 1'b0;
      else if (tick_i) sts_q[g] <= en[g];
    end
  end

  // error latch holds the halt until run/stop is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lock_q <= 1'b0;
    else if (err_halt_i)  lock_q <= 1'b1;
    else if (!run_stop_i) lock_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hch_q <= 1'b1;
    else if (err_halt_i)             hch_q <= 1'b1;
    else if (run_stop_i && !lock_q)  hch_q <= 1'b0;
    else if (!run_stop_i && tick_i)  hch_q <= 1'b1;
  end

  assign halted_o = hch_q;
  assign as_o     = sts_q[1];
  assign ps_o     = sts_q[0];

  // R2
  run_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_stop_i && !lock_q && !err_halt_i) |=> !halted_o);
  // R2
  stop_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_stop_i && !tick_i && !err_halt_i && !halted_o) |=> !halted_o);
  // R3
  err_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_halt_i |=> halted_o);
  // R6
  sched_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(as_o) && $stable(ps_o)));
endmodule

// File: rtl/usbh_status_unit.sv
module usbh_status_unit
  import usbh_sts_pkg::*;
#(
  parameter int unsigned CLK_DIV = 7500,
  parameter int unsigned IDX_W   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_stop_i,
  input  logic             async_en_i,
  input  logic             periodic_en_i,
  input  logic [1:0]       fl_size_i,
  input  logic             doorbell_i,
  input  logic             adv_done_i,
  input  logic             async_empty_i,
  input  logic             err_halt_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [REG_W-1:0] intr_en_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [IDX_W-1:0] frame_idx_o,
  output logic             irq_o
);
  localparam int unsigned N_W1C = 3;
  localparam int unsigned W1C_POS [N_W1C] = '{FRI_BIT, AAI_BIT, SRI_BIT};
  localparam logic [REG_W-1:0] W1C_MASK =
    (REG_W'(1) << FRI_BIT) | (REG_W'(1) << AAI_BIT) | (REG_W'(1) << SRI_BIT);

  logic tick, halted, as_sts, ps_sts, adv, roll;
  logic armed_q, rcl_q;
  logic [N_W1C-1:0] w1c_set, w1c_q;
  logic unused_wdata;

  usbh_uframe_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  usbh_sched_state u_sched (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .run_stop_i    (run_stop_i),
    .err_halt_i    (err_halt_i),
    .async_en_i    (async_en_i),
    .periodic_en_i (periodic_en_i),
    .halted_o      (halted),
    .as_o          (as_sts),
    .ps_o          (ps_sts)
  );

  assign adv = tick & run_stop_i & ~halted;

  usbh_frame_index #(.IDX_W(IDX_W)) u_fidx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .fl_size_i (fl_size_i),
    .idx_o     (frame_idx_o),
    .roll_o    (roll)
  );

  // doorbell arms one advance report
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (doorbell_i) armed_q <= 1'b1;
    else if (adv_done_i) armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rcl_q <= 1'b0;
    else if (async_empty_i) rcl_q <= 1'b1;
    else if (tick)          rcl_q <= 1'b0;
  end

  assign w1c_set[0] = roll;
  assign w1c_set[1] = adv_done_i & armed_q;
  assign w1c_set[2] = tick & ~halted;

  for (genvar g = 0; g < N_W1C; g++) begin : g_w1c
    logic clr;
    assign clr = wr_i & wr_data_i[W1C_POS[g]];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w1c_q[g] <= 1'b0;
      else         w1c_q[g] <= w1c_set[g] | (w1c_q[g] & ~clr);
    end
  end

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[FRI_BIT] = w1c_q[0];
    rd_data_o[AAI_BIT] = w1c_q[1];
    rd_data_o[SRI_BIT] = w1c_q[2];
    rd_data_o[HCH_BIT] = halted;
    rd_data_o[RCL_BIT] = rcl_q;
    rd_data_o[PS_BIT]  = ps_sts;
    rd_data_o[AS_BIT]  = as_sts;
  end

  assign irq_o = |(rd_data_o & intr_en_i & W1C_MASK);

  assign unused_wdata = ^wr_data_i;

  // R5
  sof_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !halted) |=> rd_data_o[SRI_BIT]);
  // R7
  aai_nobell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_done_i && !armed_q && !rd_data_o[AAI_BIT]) |=> !rd_data_o[AAI_BIT]);
  // R8
  rcl_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !async_empty_i) |=> !rd_data_o[RCL_BIT]);
  // R9
  fri_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll |=> rd_data_o[FRI_BIT]);
  // R10
  w1c_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i[AAI_BIT] && !(adv_done_i && armed_q)) |=> !rd_data_o[AAI_BIT]);
  // R10
  sei_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_i) |=> !rd_data_o[SEI_BIT]);
endmodule

// File: tb/usbh_status_unit_tb_top.sv
module usbh_status_unit_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DIV        = 4;
  localparam int unsigned WD_CYCLES  = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_stop_i = 1'b0, async_en_i = 1'b0, periodic_en_i = 1'b0;
  logic [1:0]  fl_size_i = 2'd0;
  logic        doorbell_i = 1'b0, adv_done_i = 1'b0, async_empty_i = 1'b0, err_halt_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wr_data_i = '0, intr_en_i = '0;
  logic [31:0] rd_data_o;
  logic [13:0] frame_idx_o;
  logic        irq_o;

  int unsigned n_chk = 0, n_err = 0, ph = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usbh_status_unit #(.CLK_DIV(DIV), .IDX_W(14)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_stop_i(run_stop_i), .async_en_i(async_en_i),
    .periodic_en_i(periodic_en_i), .fl_size_i(fl_size_i), .doorbell_i(doorbell_i),
    .adv_done_i(adv_done_i), .async_empty_i(async_empty_i), .err_halt_i(err_halt_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .intr_en_i(intr_en_i), .rd_data_o(rd_data_o),
    .frame_idx_o(frame_idx_o), .irq_o(irq_o)
  );

  // bench model of the boundary phase: ph==0 after a boundary edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph <= 0;
    else         ph <= (ph == DIV-1) ? 0 : ph + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk_i); while (ph != 0);
  endtask

  task automatic w1c(input logic [31:0] d);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic run_to(input logic [13:0] tgt);
    while (frame_idx_o != tgt) wait_tick();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 status", rd_data_o, 32'h0000_1000);
    chk("R1 index", 32'(frame_idx_o), 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
  endtask

  task automatic t_start();
    run_stop_i = 1'b1;
    @(negedge clk_i);
    chk("R2 run clears halted", 32'(rd_data_o[12]), 32'd0);
  endtask

  task automatic t_sof();
    wait_tick();
    chk("R5 sof set", 32'(rd_data_o[7]), 32'd1);
    intr_en_i = 32'h80;
    #1 chk("R11 irq on sof", 32'(irq_o), 32'd1);
    w1c(32'h80);
    chk("R5 sof cleared", 32'(rd_data_o[7]), 32'd0);
    chk("R11 irq drops", 32'(irq_o), 32'd0);
    intr_en_i = 32'h0;
  endtask

  task automatic t_sched();
    wait_tick();
    async_en_i = 1'b1; periodic_en_i = 1'b1;
    @(negedge clk_i);
    chk("R6 no early follow", 32'(rd_data_o[15:14]), 32'd0);
    wait_tick();
    chk("R6 follow at boundary", 32'(rd_data_o[15:14]), 32'd3);
    w1c(32'hFFFF_FFFF);
    chk("R10 write-all leaves only schedule bits", rd_data_o, 32'h0000_C000);
    async_en_i = 1'b0;
    @(negedge clk_i);
    chk("R6 async off lags", 32'(rd_data_o[15]), 32'd1);
    wait_tick();
    chk("R6 async off at boundary", 32'(rd_data_o[15:14]), 32'd1);
  endtask

  task automatic t_index();
    logic [13:0] f0;
    wait_tick();
    f0 = frame_idx_o;
    repeat (3) wait_tick();
    chk("R4 index steps", 32'(frame_idx_o), 32'(f0 + 14'd3));
  endtask

  task automatic t_aai();
    adv_done_i = 1'b1;
    @(negedge clk_i);
    adv_done_i = 1'b0;
    @(negedge clk_i);
    chk("R7 done without doorbell ignored", 32'(rd_data_o[5]), 32'd0);
    doorbell_i = 1'b1;
    @(negedge clk_i);
    doorbell_i = 1'b0;
    adv_done_i = 1'b1; wr_i = 1'b1; wr_data_i = 32'h20;
    @(negedge clk_i);
    adv_done_i = 1'b0; wr_i = 1'b0; wr_data_i = '0;
    chk("R10 set wins over clear", 32'(rd_data_o[5]), 32'd1);
    intr_en_i = 32'h20;
    #1 chk("R11 irq on aai", 32'(irq_o), 32'd1);
    w1c(32'h20);
    chk("R7 aai cleared", 32'(rd_data_o[5]), 32'd0);
    intr_en_i = 32'h0;
  endtask

  task automatic t_rcl();
    wait_tick();
    async_empty_i = 1'b1;
    @(negedge clk_i);
    async_empty_i = 1'b0;
    chk("R8 reclamation set", 32'(rd_data_o[13]), 32'd1);
    w1c(32'h2000);
    chk("R10 reclamation not writable", 32'(rd_data_o[13]), 32'd1);
    wait_tick();
    chk("R8 reclamation cleared at boundary", 32'(rd_data_o[13]), 32'd0);
  endtask

  task automatic t_roll();
    fl_size_i = 2'd2;
    run_to(14'h07FF);
    w1c(32'h8);
    chk("R9 clear before wrap", 32'(rd_data_o[3]), 32'd0);
    wait_tick();
    chk("R9 256 wrap index", 32'(frame_idx_o), 32'h800);
    chk("R9 256 wrap flag", 32'(rd_data_o[3]), 32'd1);
    w1c(32'h8);
    fl_size_i = 2'd1;
    run_to(14'h0FFF);
    chk("R9 512 no flag early", 32'(rd_data_o[3]), 32'd0);
    wait_tick();
    chk("R9 512 wrap flag", 32'(rd_data_o[3]), 32'd1);
    w1c(32'h8);
    run_to(14'h1800);
    chk("R9 512 ignores bit11 toggle", 32'(rd_data_o[3]), 32'd0);
    fl_size_i = 2'd0;
    run_to(14'h1FFF);
    w1c(32'h8);
    wait_tick();
    chk("R9 1024 bit13 rise", 32'(rd_data_o[3]), 32'd1);
    w1c(32'h8);
    run_to(14'h3FFF);
    chk("R9 1024 no flag early", 32'(rd_data_o[3]), 32'd0);
    wait_tick();
    chk("R9 1024 wrap index", 32'(frame_idx_o), 32'd0);
    chk("R9 1024 wrap flag", 32'(rd_data_o[3]), 32'd1);
  endtask

  task automatic t_halt();
    logic [13:0] f0;
    wait_tick();
    run_stop_i = 1'b0;
    f0 = frame_idx_o;
    @(negedge clk_i);
    chk("R2 halt waits for boundary", 32'(rd_data_o[12]), 32'd0);
    wait_tick();
    chk("R2 halted at boundary", 32'(rd_data_o[12]), 32'd1);
    chk("R4 index holds on stop", 32'(frame_idx_o), 32'(f0));
    w1c(32'h80);
    wait_tick();
    chk("R5 no sof while halted", 32'(rd_data_o[7]), 32'd0);
    chk("R4 index holds while halted", 32'(frame_idx_o), 32'(f0));
  endtask

  task automatic t_err();
    logic [13:0] f0;
    run_stop_i = 1'b1;
    @(negedge clk_i);
    chk("R2 restart", 32'(rd_data_o[12]), 32'd0);
    err_halt_i = 1'b1;
    @(negedge clk_i);
    err_halt_i = 1'b0;
    chk("R3 error halts at once", 32'(rd_data_o[12]), 32'd1);
    f0 = frame_idx_o;
    wait_tick();
    chk("R3 stays halted with run high", 32'(rd_data_o[12]), 32'd1);
    chk("R3 index frozen", 32'(frame_idx_o), 32'(f0));
    run_stop_i = 1'b0;
    @(negedge clk_i);
    run_stop_i = 1'b1;
    @(negedge clk_i);
    chk("R3 restart after stop", 32'(rd_data_o[12]), 32'd0);
  endtask

  initial begin
    t_reset();
    t_start();
    t_sof();
    t_sched();
    t_index();
    t_aai();
    t_rcl();
    t_roll();
    t_halt();
    t_err();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule